// File: doc/BRIEF.md
# Paper Tape Reader and Punch Controller

This block is the device-side controller for a paper tape reader and a paper tape punch that share one device slot on a byte-wide programmed-I/O bus. The host writes command bytes that pick which mechanism is selected (reader or punch), start or stop the reader, choose between continuous (slew) and one-character-per-read (step) reader motion, and arm or disarm the interrupt. The host reads characters from a one-byte reader buffer, writes characters into a one-byte punch buffer, and reads a status byte that always describes the selected mechanism.

Tape motion is not modelled inside the block. The block asks the reader to move by holding `rdr_req` high. The reader answers with a character strobe or an end-of-tape strobe. The block asks for a punch cycle by holding `pun_req` high, and the punch ends that cycle with a completion strobe. Bus address decoding is done outside the block. The three host strobes (`cmd_we`, `rd_re`, `wr_we`) are mutually exclusive. When a mechanism strobe and a host strobe fall in the same cycle, the host strobe's effect on a shared bit wins.

Top module: `tape_rp_ctrl`

## Requirements
- R1: A command byte holds four 2-bit fields: direction in bits 1:0 (set means reader), motion mode in bits 3:2 (set means slew), run in bits 5:4 and interrupt arm in bits 7:6. In every field, code 01 sets the mode, code 10 clears it, and codes 00 and 11 leave it unchanged.
- R2: A command that changes the direction clears overrun (status bit 7). If the newly selected mechanism is still moving, busy (status bit 3) is set and `irq` drops. Otherwise busy clears and, if the interrupt is armed, `irq` rises. A command that leaves the direction unchanged does not alter `irq`, except for a disarm.
- R3: In reader direction, a run change from 0 to 1 raises `rdr_req` and clears device-unavailable (status bit 0). A run-clear command lowers `rdr_req` at once. Any command issued in punch direction clears device-unavailable.
- R4: `rd_data` always shows the reader buffer. A data read (`rd_re`) clears the pending-character flag and drops `irq`, and in reader direction it sets busy. If run is set and step mode is selected, the data read also raises `rdr_req` and clears device-unavailable. In slew mode a data read does not raise `rdr_req`.
- R5: A character strobe is accepted only while `rdr_req` is high, and it loads the reader buffer. In reader direction an accepted character clears busy, raises `irq` if armed, and sets overrun if the previous character was never read. In step mode the character lowers `rdr_req`; in slew mode `rdr_req` stays high. A character strobe that arrives while `rdr_req` is low changes nothing.
- R6: A data write latches `wr_data` into the punch buffer (shown on `pun_data`) and raises `pun_req`. It sets busy only in punch direction. `pun_done` lowers `pun_req`. In punch direction, `pun_done` also clears busy and raises `irq` if armed.
- R7: The status byte is computed continuously. No-motion (bit 4) is 1 in reader direction when run is clear and `rdr_req` is low. Device-unavailable is also 1 whenever the selected mechanism's online input is low. Exception (bit 2) is 1 exactly when overrun or no-motion is 1.
- R8: Reset selects reader direction, clears run, slew, the pending flag, arm and `irq`, and sets busy with all other stored status bits clear. The reset status with both mechanisms online is 0x1C.
- R9: An end-of-tape strobe while `rdr_req` is high sets device-unavailable and lowers `rdr_req`, without changing the reader buffer.
- R10: A disarm command drops `irq`. While the interrupt is disarmed, no event raises `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_we | input | 1 | Command byte strobe |
| cmd_data | input | 8 | Command byte |
| rd_re | input | 1 | Data read strobe |
| rd_data | output | DATA_W | Reader buffer |
| wr_we | input | 1 | Data write strobe |
| wr_data | input | DATA_W | Character to punch |
| sts | output | 8 | Status byte |
| irq | output | 1 | Interrupt request |
| rdr_req | output | 1 | Reader motion request |
| rdr_char_vld | input | 1 | Reader character strobe |
| rdr_char | input | DATA_W | Character from reader |
| rdr_eot | input | 1 | Reader end-of-tape strobe |
| rdr_online | input | 1 | Reader is online |
| pun_req | output | 1 | Punch cycle request |
| pun_data | output | DATA_W | Punch buffer |
| pun_done | input | 1 | Punch cycle complete strobe |
| pun_online | input | 1 | Punch is online |

## Verification
The bench builds the block with its default 8-bit character width. This keeps distinct byte patterns such as 0xA5, 0x3C and 0x5A traceable from the reader strobe to `rd_data`, and from `wr_data` to `pun_data`. The tests cover both motion modes and both directions, including a direction switch while the punch is mid-cycle. They also cover overrun from two unread slew characters, end-of-tape followed by a read, each online input dropped in turn, and the same events with the interrupt disarmed.

// File: rtl/tape_rp_ctrl.sv
module tape_rp_ctrl #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic [7:0]        cmd_data,
  input  logic              rd_re,
  output logic [DATA_W-1:0] rd_data,
  input  logic              wr_we,
  input  logic [DATA_W-1:0] wr_data,
  output logic [7:0]        sts,
  output logic              irq,
  output logic              rdr_req,
  input  logic              rdr_char_vld,
  input  logic [DATA_W-1:0] rdr_char,
  input  logic              rdr_eot,
  input  logic              rdr_online,
  output logic              pun_req,
  output logic [DATA_W-1:0] pun_data,
  input  logic              pun_done,
  input  logic              pun_online
);

  function automatic logic fld(input logic [1:0] c, input logic cur);
    case (c)
      2'b01:   fld = 1'b1;
      2'b10:   fld = 1'b0;
      default: fld = cur;
    endcase
  endfunction

  logic rd_mode, run, slew, arm, chp, busy, ovr, unav, rgo, pgo, irq_q;
  logic [DATA_W-1:0] rbuf, pbuf;

  logic n_rd, n_run, n_slew, n_arm, nmtn, offl;
  assign n_rd   = fld(cmd_data[1:0], rd_mode);
  assign n_slew = fld(cmd_data[3:2], slew);
  assign n_run  = fld(cmd_data[5:4], run);
  assign n_arm  = fld(cmd_data[7:6], arm);

  assign nmtn = rd_mode & ~run & ~rgo;
  assign offl = rd_mode ? ~rdr_online : ~pun_online;
  assign sts  = {ovr, 2'b00, nmtn, busy, ovr | nmtn, 1'b0, unav | offl};

  assign rd_data  = rbuf;
  assign pun_data = pbuf;
  assign rdr_req  = rgo;
  assign pun_req  = pgo;
  assign irq      = irq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_mode <= 1'b1;
      run     <= 1'b0;
      slew    <= 1'b0;
      arm     <= 1'b0;
      chp     <= 1'b0;
      busy    <= 1'b1;
      ovr     <= 1'b0;
      unav    <= 1'b0;
      rgo     <= 1'b0;
      pgo     <= 1'b0;
      irq_q   <= 1'b0;
      rbuf    <= '0;
      pbuf    <= '0;
    end else begin
      // mechanism events first; a host strobe in the same cycle overrides
      if (rdr_char_vld && rgo) begin
        if (rd_mode) begin
          busy <= 1'b0;
          if (arm) irq_q <= 1'b1;
          if (chp) ovr <= 1'b1;
        end
        chp  <= 1'b1;
        rbuf <= rdr_char;
        if (!slew) rgo <= 1'b0;
      end else if (rdr_eot && rgo) begin
        unav <= 1'b1;
        rgo  <= 1'b0;
      end
      if (pun_done && pgo) begin
        pgo <= 1'b0;
        if (!rd_mode) begin
          busy <= 1'b0;
          if (arm) irq_q <= 1'b1;
        end
      end

      if (cmd_we) begin
        arm     <= n_arm;
        rd_mode <= n_rd;
        if (!n_arm) irq_q <= 1'b0;
        if (n_rd != rd_mode) begin
          ovr <= 1'b0;
          if (n_rd ? rgo : pgo) begin
            busy  <= 1'b1;
            irq_q <= 1'b0;
          end else begin
            busy <= 1'b0;
            if (n_arm) irq_q <= 1'b1;
          end
        end
        if (n_rd) begin
          run  <= n_run;
          slew <= n_slew;
          if (n_run && !run) begin
            rgo  <= 1'b1;
            unav <= 1'b0;
          end else if (!n_run) begin
            rgo <= 1'b0;
          end
        end else begin
          unav <= 1'b0;
        end
      end else if (rd_re) begin
        if (run && !slew) begin
          rgo  <= 1'b1;
          unav <= 1'b0;
        end
        chp   <= 1'b0;
        irq_q <= 1'b0;
        if (rd_mode) busy <= 1'b1;
      end else if (wr_we) begin
        pbuf  <= wr_data;
        pgo   <= 1'b1;
        irq_q <= 1'b0;
        if (!rd_mode) busy <= 1'b1;
      end
    end
  end

  assert_overrun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rdr_char_vld && rgo && rd_mode && chp && !cmd_we |=> sts[7]);

  assert_irq_armed_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> arm);

  assert_read_busy_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_re && rd_mode && !cmd_we |=> sts[3]);

  assert_stop_reader_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_we && cmd_data[1:0] == 2'b01 && cmd_data[5:4] == 2'b10 |=> !rdr_req);

  assert_punch_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_we && !cmd_we && !rd_re |=> pun_req);

endmodule

// File: tb/tape_rp_ctrl_tb.sv
module tape_rp_ctrl_tb;
  localparam int DW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_we = 0, rd_re = 0, wr_we = 0;
  logic [7:0] cmd_data = '0;
  logic [DW-1:0] wr_data = '0, rdr_char = '0;
  logic rdr_char_vld = 0, rdr_eot = 0, pun_done = 0;
  logic rdr_online = 1, pun_online = 1;
  logic [DW-1:0] rd_data, pun_data;
  logic [7:0] sts;
  logic irq, rdr_req, pun_req;

  always #2.5 clk = ~clk;

  tape_rp_ctrl #(.DATA_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_data(cmd_data),
    .rd_re(rd_re), .rd_data(rd_data), .wr_we(wr_we), .wr_data(wr_data),
    .sts(sts), .irq(irq), .rdr_req(rdr_req), .rdr_char_vld(rdr_char_vld),
    .rdr_char(rdr_char), .rdr_eot(rdr_eot), .rdr_online(rdr_online),
    .pun_req(pun_req), .pun_data(pun_data), .pun_done(pun_done),
    .pun_online(pun_online));

  typedef struct {
    string tag;
    logic [7:0] sts;
    logic [DW-1:0] rd;
    logic [DW-1:0] pd;
    logic irq, rreq, preq;
  } exp_t;

  exp_t q[$];
  int n_vec = 0, n_bad = 0;
  bit done_flag = 0;

  always begin
    @(posedge clk);
    #2;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_vec++;
      if (sts !== e.sts || rd_data !== e.rd || pun_data !== e.pd ||
          irq !== e.irq || rdr_req !== e.rreq || pun_req !== e.preq) begin
        n_bad++;
        $display("FAIL %s: got sts=%h rd=%h pd=%h irq=%b rreq=%b preq=%b, exp sts=%h rd=%h pd=%h irq=%b rreq=%b preq=%b",
                 e.tag, sts, rd_data, pun_data, irq, rdr_req, pun_req,
                 e.sts, e.rd, e.pd, e.irq, e.rreq, e.preq);
      end
    end
  end

  task automatic chk(string tag, logic [7:0] s, logic [DW-1:0] r, logic [DW-1:0] p,
                     logic i, logic rr, logic pr);
    exp_t e;
    e.tag = tag; e.sts = s; e.rd = r; e.pd = p; e.irq = i; e.rreq = rr; e.preq = pr;
    @(negedge clk);
    q.push_back(e);
    @(negedge clk);
  endtask

  task automatic pulse_cmd(logic [7:0] b);
    @(negedge clk); cmd_we = 1; cmd_data = b;
    @(negedge clk); cmd_we = 0;
  endtask
  task automatic pulse_rd();
    @(negedge clk); rd_re = 1;
    @(negedge clk); rd_re = 0;
  endtask
  task automatic pulse_wr(logic [DW-1:0] b);
    @(negedge clk); wr_we = 1; wr_data = b;
    @(negedge clk); wr_we = 0;
  endtask
  task automatic pulse_chr(logic [DW-1:0] b);
    @(negedge clk); rdr_char_vld = 1; rdr_char = b;
    @(negedge clk); rdr_char_vld = 0;
  endtask
  task automatic pulse_eot();
    @(negedge clk); rdr_eot = 1;
    @(negedge clk); rdr_eot = 0;
  endtask
  task automatic pulse_done();
    @(negedge clk); pun_done = 1;
    @(negedge clk); pun_done = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R8 reset state", 8'h1C, 8'h00, 8'h00, 0, 0, 0);
    pulse_cmd(8'h41);
    chk("R1 arm only, no-change fields", 8'h1C, 8'h00, 8'h00, 0, 0, 0);
    pulse_cmd(8'h11);
    chk("R3 run 0->1 starts reader", 8'h08, 8'h00, 8'h00, 0, 1, 0);
    pulse_chr(8'hA5);
    chk("R5 step char arrival", 8'h00, 8'hA5, 8'h00, 1, 0, 0);
    pulse_chr(8'h3C);
    chk("R5 char while reader idle ignored", 8'h00, 8'hA5, 8'h00, 1, 0, 0);
    pulse_rd();
    chk("R4 step read requests next", 8'h08, 8'hA5, 8'h00, 0, 1, 0);
    pulse_chr(8'h3C);
    chk("R5 second step char", 8'h00, 8'h3C, 8'h00, 1, 0, 0);
    pulse_cmd(8'h04);
    chk("R1 slew set, run kept", 8'h00, 8'h3C, 8'h00, 1, 0, 0);
    pulse_cmd(8'h20);
    chk("R7 stopped reader no-motion", 8'h14, 8'h3C, 8'h00, 1, 0, 0);
    pulse_cmd(8'h10);
    chk("R3 restart in slew", 8'h00, 8'h3C, 8'h00, 1, 1, 0);
    pulse_chr(8'h11);
    chk("R5 overrun, slew continues", 8'h84, 8'h11, 8'h00, 1, 1, 0);
    pulse_chr(8'h22);
    chk("R5 slew next char", 8'h84, 8'h22, 8'h00, 1, 1, 0);
    pulse_eot();
    chk("R9 end of tape", 8'h85, 8'h22, 8'h00, 1, 0, 0);
    pulse_rd();
    chk("R4 slew read no request", 8'h8D, 8'h22, 8'h00, 0, 0, 0);
    pulse_cmd(8'h02);
    chk("R2 switch to idle punch", 8'h00, 8'h22, 8'h00, 1, 0, 0);
    pulse_wr(8'h5A);
    chk("R6 punch write", 8'h08, 8'h22, 8'h5A, 0, 0, 1);
    pulse_cmd(8'h01);
    chk("R2 switch to idle reader", 8'h00, 8'h22, 8'h5A, 1, 0, 1);
    pulse_cmd(8'h02);
    chk("R2 switch to moving punch", 8'h08, 8'h22, 8'h5A, 0, 0, 1);
    pulse_done();
    chk("R6 punch done", 8'h00, 8'h22, 8'h5A, 1, 0, 0);
    @(negedge clk); pun_online = 0;
    chk("R7 punch offline", 8'h01, 8'h22, 8'h5A, 1, 0, 0);
    @(negedge clk); pun_online = 1;
    pulse_cmd(8'h80);
    chk("R10 disarm drops irq", 8'h00, 8'h22, 8'h5A, 0, 0, 0);
    pulse_wr(8'h77);
    pulse_done();
    chk("R10 done while disarmed", 8'h00, 8'h22, 8'h77, 0, 0, 0);
    pulse_cmd(8'h01);
    chk("R2 disarmed switch no irq", 8'h00, 8'h22, 8'h77, 0, 0, 0);
    pulse_cmd(8'h20);
    chk("R7 exception from no-motion", 8'h14, 8'h22, 8'h77, 0, 0, 0);
    pulse_wr(8'h99);
    chk("R6 write in reader dir no busy", 8'h14, 8'h22, 8'h99, 0, 0, 1);
    pulse_done();
    chk("R6 done in reader dir", 8'h14, 8'h22, 8'h99, 0, 0, 0);
    @(negedge clk); rdr_online = 0;
    chk("R7 reader offline", 8'h15, 8'h22, 8'h99, 0, 0, 0);
    @(negedge clk); rdr_online = 1; rst_n = 0;
    @(negedge clk); rst_n = 1;
    chk("R8 reset again", 8'h1C, 8'h00, 8'h00, 0, 0, 0);
    repeat (3) @(negedge clk);
    done_flag = 1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done_flag) break;
    end
    if (!done_flag) begin
      n_bad++;
      n_vec++;
      $display("FAIL watchdog: got timeout, exp completion");
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule